// File: doc/BRIEF.md
# Bus Device Enumeration Search Engine

This block sits on the master side of a single-wire, open-drain multidrop bus. It finds the ROM identifiers of every slave on the bus, one identifier per pass. It does not time the bus slots itself. Instead it hands single requests to a bit-level slot engine and waits for each result. The requests are a reset with presence sense, a write of one bit, and a read of one bit.

Each pass follows the same sequence. The engine first resets the bus and confirms that a slave answered. It then sends the search opcode. Next it walks the identifier bit by bit. For each position it reads the bit, reads its complement, and writes back the direction it chose. Writing that direction drops every slave that disagrees for the rest of the pass.

Between passes the engine remembers the deepest position where it went the 0 way at a disagreement. The next pass repeats the earlier choices up to that position and takes the 1 branch there. Each identifier found is shown on `rom_code` together with a one-cycle `rom_valid` strobe. A done flag rises when a pass ends without any open branch.

Top module: `owm_search`

## Requirements
- R1: After reset, `busy`, `rom_valid`, `req_valid`, `search_done`, `err_no_presence` and `err_no_device` are all 0.
- R2: Every pass opens with one reset request (`req_op` = 0). If `resp_bit` returns 0 for that request, `err_no_presence` rises, `busy` falls, and the pass ends with no further request and no `rom_valid`.
- R3: After presence, the engine sends 8 write requests (`req_op` = 1) carrying the opcode least significant bit first: F0h when `alarm_sel` is 0 and ECh when it is 1. `alarm_sel` is sampled when a pass starts.
- R4: After the opcode, for each of the ROM_W identifier positions in turn (bit 0 first), the engine issues a read (`req_op` = 2), a second read, and then a write.
- R5: When the two reads differ, the written bit equals the first read.
- R6: When both reads are 0, the written bit follows a fixed rule. It is 1 at the branch position remembered from the previous pass. It is 0 beyond that position. Before that position it repeats the bit written in the previous pass. The first pass therefore takes 0 at every disagreement, and successive passes report the identifiers in ascending order of their bit-reversed value.
- R7: When both reads are 1, the pass aborts. `err_no_device` rises, `busy` falls, and no write, `rom_valid` or further request follows.
- R8: At the end of a full pass, `rom_valid` pulses for one cycle with `busy` low. `rom_code` bit k holds the bit written at position k.
- R9: Over repeated passes, every slave identifier is reported exactly once.
- R10: When a pass ends with no remembered branch, `search_done` rises. While `search_done` or an error flag is set, `next_pass` starts no request.
- R11: `start` clears the branch memory, `search_done` and both error flags, then runs a first pass. `start` and `next_pass` are ignored while `busy`.
- R12: `req_valid` is a one-cycle pulse. No new request is issued until `resp_done` answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear search state and run the first pass |
| next_pass | input | 1 | Run the following pass |
| alarm_sel | input | 1 | Selects the alarm-only search opcode |
| req_valid | output | 1 | One-cycle slot request strobe |
| req_op | output | 2 | Slot kind: 0 reset, 1 write, 2 read |
| req_wbit | output | 1 | Bit to send on a write slot |
| resp_done | input | 1 | Slot engine finished the request |
| resp_bit | input | 1 | Read value, or presence seen after reset |
| busy | output | 1 | A pass is running |
| rom_valid | output | 1 | One-cycle strobe for a found identifier |
| rom_code | output | ROM_W | Identifier found, bit 0 first on the bus |
| search_done | output | 1 | No devices remain to be found |
| err_no_presence | output | 1 | No presence answer to the reset |
| err_no_device | output | 1 | Both reads returned 1 |

## Verification
The bench builds the engine with ROM_W = 3, so that only eight identifiers are possible. It sweeps every one of the 256 device populations, including the empty bus, and alternates the opcode selector between populations. At this width every branching pattern of the search tree is reachable: the bench covers disagreements at each depth, identifiers that share long prefixes, and full populations that need the maximum number of passes. A bench slave model forms the wired-AND of all selected identifiers. Expected discovery order is computed from bit-reversed values, and a forced double-1 read exercises the abort path.

// File: rtl/owm_search_pkg.sv
package owm_search_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_ALARM  = 8'hEC;

  localparam logic [1:0] OP_RESET = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_CMD, ST_RDA, ST_RDB, ST_WR, ST_END
  } srch_state_t;
endpackage

// File: rtl/srch_cmd_ser.sv
module srch_cmd_ser
  import owm_search_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic alarm,
  input  logic shift,
  output logic bit_o,
  output logic last_o
);
  localparam int CW = CMD_W;
  localparam int CNTW = $clog2(CW);

  logic [CW-1:0]   sh_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= alarm ? CMD_ALARM : CMD_SEARCH;
      cnt_q <= '0;
    end else if (shift) begin
      sh_q  <= {1'b0, sh_q[CW-1:1]};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = sh_q[0];
  assign last_o = (cnt_q == CNTW'(CW-1));
endmodule

// File: rtl/srch_branch.sv
module srch_branch #(
  parameter int DW = 7
) (
  input  logic          rd_a,
  input  logic          rd_b,
  input  logic [DW-1:0] pos,
  input  logic [DW-1:0] last_disc,
  input  logic          prev_bit,
  output logic          dir,
  output logic          conflict
);
  always_comb begin
    conflict = 1'b0;
    if (rd_a != rd_b) begin
      dir = rd_a;
    end else begin
      conflict = ~rd_a;
      if (pos < last_disc)       dir = prev_bit;
      else if (pos == last_disc) dir = 1'b1;
      else                       dir = 1'b0;
    end
  end
endmodule

// File: rtl/owm_search.sv
module owm_search
  import owm_search_pkg::*;
#(
  parameter int ROM_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             next_pass,
  input  logic             alarm_sel,
  output logic             req_valid,
  output logic [1:0]       req_op,
  output logic             req_wbit,
  input  logic             resp_done,
  input  logic             resp_bit,
  output logic             busy,
  output logic             rom_valid,
  output logic [ROM_W-1:0] rom_code,
  output logic             search_done,
  output logic             err_no_presence,
  output logic             err_no_device
);
  localparam int IDXW = (ROM_W > 1) ? $clog2(ROM_W) : 1;
  localparam int DW   = $clog2(ROM_W + 1);

  srch_state_t      st_q;
  logic             pend_q;
  logic [ROM_W-1:0] rom_q;
  logic [IDXW-1:0]  idx_q;
  logic [DW-1:0]    last_disc_q, new_disc_q;
  logic             rd_a_q, rd_b_q;
  logic             busy_q, done_q, errp_q, errd_q, rv_q;
  logic             rv_req_q, wbit_q;
  logic [1:0]       op_q;

  logic cmd_bit, cmd_last, cmd_load, cmd_shift;
  logic dir, conflict;
  logic [DW-1:0] pos;
  logic go_first, go_next;

  assign pos      = DW'(idx_q) + 1'b1;
  assign go_first = (st_q == ST_IDLE) && start;
  assign go_next  = (st_q == ST_IDLE) && !start && next_pass && !done_q && !errp_q && !errd_q;
  assign cmd_load = go_first || go_next;
  assign cmd_shift = (st_q == ST_CMD) && pend_q && resp_done && !cmd_last;

  srch_cmd_ser u_cmd (
    .clk(clk), .rst(rst), .load(cmd_load), .alarm(alarm_sel),
    .shift(cmd_shift), .bit_o(cmd_bit), .last_o(cmd_last)
  );

  srch_branch #(.DW(DW)) u_br (
    .rd_a(rd_a_q), .rd_b(rd_b_q), .pos(pos), .last_disc(last_disc_q),
    .prev_bit(rom_q[idx_q]), .dir(dir), .conflict(conflict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      pend_q      <= 1'b0;
      rom_q       <= '0;
      idx_q       <= '0;
      last_disc_q <= '0;
      new_disc_q  <= '0;
      rd_a_q      <= 1'b0;
      rd_b_q      <= 1'b0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      errp_q      <= 1'b0;
      errd_q      <= 1'b0;
      rv_q        <= 1'b0;
      rv_req_q    <= 1'b0;
      wbit_q      <= 1'b0;
      op_q        <= OP_RESET;
    end else begin
      rv_req_q <= 1'b0;
      rv_q     <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (go_first) begin
            last_disc_q <= '0;
            done_q      <= 1'b0;
            errp_q      <= 1'b0;
            errd_q      <= 1'b0;
            rom_q       <= '0;
          end
          if (go_first || go_next) begin
            busy_q <= 1'b1;
            st_q   <= ST_RST;
          end
        end
        ST_RST: begin
          if (!pend_q) begin
            rv_req_q <= 1'b1;
            op_q     <= OP_RESET;
            pend_q   <= 1'b1;
          end else if (resp_done) begin
            pend_q <= 1'b0;
            if (resp_bit) begin
              st_q       <= ST_CMD;
              new_disc_q <= '0;
              idx_q      <= '0;
            end else begin
              errp_q <= 1'b1;
              busy_q <= 1'b0;
              st_q   <= ST_IDLE;
            end
          end
        end
        ST_CMD: begin
          if (!pend_q) begin
            rv_req_q <= 1'b1;
            op_q     <= OP_WRITE;
            wbit_q   <= cmd_bit;
            pend_q   <= 1'b1;
          end else if (resp_done) begin
            pend_q <= 1'b0;
            if (cmd_last) st_q <= ST_RDA;
          end
        end
        ST_RDA: begin
          if (!pend_q) begin
            rv_req_q <= 1'b1;
            op_q     <= OP_READ;
            pend_q   <= 1'b1;
          end else if (resp_done) begin
            pend_q <= 1'b0;
            rd_a_q <= resp_bit;
            st_q   <= ST_RDB;
          end
        end
        ST_RDB: begin
          if (!pend_q) begin
            rv_req_q <= 1'b1;
            op_q     <= OP_READ;
            pend_q   <= 1'b1;
          end else if (resp_done) begin
            pend_q <= 1'b0;
            rd_b_q <= resp_bit;
            if (rd_a_q && resp_bit) begin
              errd_q <= 1'b1;
              busy_q <= 1'b0;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (!pend_q) begin
            rv_req_q     <= 1'b1;
            op_q         <= OP_WRITE;
            wbit_q       <= dir;
            rom_q[idx_q] <= dir;
            pend_q       <= 1'b1;
            if (conflict && !dir) new_disc_q <= pos;
          end else if (resp_done) begin
            pend_q <= 1'b0;
            if (idx_q == IDXW'(ROM_W-1)) begin
              st_q <= ST_END;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_RDA;
            end
          end
        end
        ST_END: begin
          rv_q        <= 1'b1;
          last_disc_q <= new_disc_q;
          done_q      <= (new_disc_q == '0);
          busy_q      <= 1'b0;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid       = rv_req_q;
  assign req_op          = op_q;
  assign req_wbit        = wbit_q;
  assign busy            = busy_q;
  assign rom_valid       = rv_q;
  assign rom_code        = rom_q;
  assign search_done     = done_q;
  assign err_no_presence = errp_q;
  assign err_no_device   = errd_q;

  // R12
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R5
  forced_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WR && !pend_q && (rd_a_q != rd_b_q)) |=> (req_wbit == $past(rd_a_q)));

  // R6
  fresh_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WR && !pend_q && !rd_a_q && !rd_b_q && (pos > last_disc_q)) |=> !req_wbit);

  // R7
  nodev_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RDB && pend_q && resp_done && rd_a_q && resp_bit) |=> (err_no_device && !busy && !req_valid));

  // R2
  nopres_abort_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_no_presence) |-> (!busy && !rom_valid));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    search_done |-> (!busy && !req_valid));
endmodule

// File: tb/sim_owm_search.sv
module sim_owm_search;
  localparam int W = 3;
  localparam int ND = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, next_pass = 1'b0, alarm_sel = 1'b0;
  logic req_valid, req_wbit, busy, rom_valid, search_done, err_no_presence, err_no_device;
  logic [1:0] req_op;
  logic resp_done = 1'b0, resp_bit = 1'b0;
  logic [W-1:0] rom_code;

  always #5 clk = ~clk;

  owm_search #(.ROM_W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .next_pass(next_pass), .alarm_sel(alarm_sel),
    .req_valid(req_valid), .req_op(req_op), .req_wbit(req_wbit),
    .resp_done(resp_done), .resp_bit(resp_bit), .busy(busy), .rom_valid(rom_valid),
    .rom_code(rom_code), .search_done(search_done),
    .err_no_presence(err_no_presence), .err_no_device(err_no_device)
  );

  int checks = 0, fails = 0;
  logic [ND-1:0] dev_mask = '0;
  logic [ND-1:0] sel = '0;
  int sn = 0, ra = 0, rb = 0, req_count = 0, fault_bit = -1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rev(input int c);
    int r = 0;
    for (int i = 0; i < W; i++) r |= ((c >> i) & 1) << (W - 1 - i);
    return r;
  endfunction

  // slot engine and slave population model
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        int op, wb, idx, t, ph, bi, rbit;
        logic [7:0] cmd;
        op = int'(req_op); wb = int'(req_wbit); rbit = 0;
        req_count++;
        cmd = alarm_sel ? 8'hEC : 8'hF0;
        if (op == 0) begin
          sel = dev_mask; sn = 0;
          rbit = (dev_mask != '0) ? 1 : 0;
        end else begin
          idx = sn - 1;
          if (idx < 8) begin
            // R3
            chk(op == 1 && wb == int'(cmd[idx]), "R3 opcode bit", wb, int'(cmd[idx]));
          end else begin
            t = idx - 8; ph = t % 3; bi = t / 3;
            // R4
            chk(t < 3 * W && op == ((ph < 2) ? 2 : 1), "R4 slot order", op, (ph < 2) ? 2 : 1);
            if (ph == 0) begin
              ra = 1;
              for (int d = 0; d < ND; d++) if (sel[d]) ra &= (d >> bi) & 1;
              if (bi == fault_bit) ra = 1;
              rbit = ra;
            end else if (ph == 1) begin
              rb = 1;
              for (int d = 0; d < ND; d++) if (sel[d]) rb &= ~(d >> bi) & 1;
              if (bi == fault_bit) rb = 1;
              rbit = rb;
            end else begin
              // R5
              if (ra != rb) chk(wb == ra, "R5 forced write", wb, ra);
              for (int d = 0; d < ND; d++) if (((d >> bi) & 1) != wb) sel[d] = 1'b0;
            end
          end
        end
        sn++;
        @(negedge clk);
        // R12
        chk(!req_valid, "R12 single outstanding", int'(req_valid), 0);
        resp_done = 1'b1; resp_bit = rbit[0];
        @(negedge clk);
        resp_done = 1'b0; resp_bit = 1'b0;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_next();
    @(negedge clk) next_pass = 1'b1;
    @(negedge clk) next_pass = 1'b0;
  endtask

  // waits for the pass to end; returns code seen (or -1)
  task automatic wait_pass(output int code);
    code = -1;
    forever begin
      @(negedge clk);
      if (rom_valid) code = int'(rom_code);
      if (!busy) break;
    end
  endtask

  task automatic run_pop(input logic [ND-1:0] m, input logic al);
    int exp_list[ND];
    int cnt = 0, nf = 0, code, rc;
    for (int r = 0; r < ND; r++) if (m[rev(r)]) begin exp_list[cnt] = rev(r); cnt++; end
    dev_mask = m; alarm_sel = al;
    pulse_start();
    for (int p = 0; p <= ND; p++) begin
      wait_pass(code);
      if (cnt == 0) begin
        // R2
        chk(err_no_presence && code == -1, "R2 no presence", code, -1);
        break;
      end
      // R8 R9 R6
      chk(nf < cnt && code == exp_list[nf], "R8 R9 R6 found code", code, (nf < cnt) ? exp_list[nf] : -1);
      nf++;
      if (nf >= cnt || code == -1) break;
      // R10
      chk(!search_done, "R10 done early", int'(search_done), 0);
      pulse_next();
    end
    if (cnt != 0) begin
      // R9 R10
      chk(nf == cnt && search_done, "R9 R10 all found then done", nf, cnt);
      rc = req_count;
      pulse_next();
      repeat (10) @(negedge clk);
      // R10
      chk(req_count == rc && !busy, "R10 next ignored when done", req_count - rc, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    repeat (170000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int code, rc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !rom_valid && !req_valid && !search_done && !err_no_presence && !err_no_device,
        "R1 reset state", int'({busy, rom_valid, req_valid, search_done, err_no_presence, err_no_device}), 0);

    for (int m = 0; m < (1 << ND); m++) run_pop(ND'(m), m[0]);

    // R7 forced double-1 read on position 1
    fault_bit = 1; dev_mask = '1; alarm_sel = 1'b0;
    pulse_start();
    wait_pass(code);
    chk(err_no_device && code == -1 && !search_done, "R7 abort on no response", code, -1);
    rc = req_count;
    pulse_next();
    repeat (10) @(negedge clk);
    // R10
    chk(req_count == rc, "R10 next ignored after error", req_count - rc, 0);
    fault_bit = -1;

    // R11 start clears errors and branch memory mid-search
    pulse_start();
    wait_pass(code);
    chk(!err_no_device && code == 0, "R11 restart clears error", code, 0);
    pulse_next();
    wait_pass(code);
    chk(code == 4, "R11 second pass", code, 4);
    pulse_start();
    wait_pass(code);
    chk(code == 0 && !search_done, "R11 restart from first", code, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule